// File: doc/BRIEF.md
# Converter Result Register Bank with FIFO Interrupt

This block is the software-visible face of a slow-sampling analog-to-digital converter. It sits on a simple synchronous bus with single-beat transfers. On that bus it offers:

- a master interrupt enable;
- an interrupt status register and an interrupt enable register;
- a control word that holds the settle-time multiplier;
- a read port that pops conversion results from an internal 16-deep, 16-bit FIFO;
- a FIFO occupancy counter.

The converter core pushes each finished result into the FIFO through a valid/ready stream port. The port accepts a result on a clock edge where `res_valid` and `res_ready` are both high. `res_ready` is low exactly when the FIFO holds 16 entries. A producer that keeps `res_valid` high while `res_ready` is low is stalled, not overrun. A producer that cannot wait loses that sample, because the block never stores more than 16 entries.

There is a single interrupt source: the FIFO is not empty. While the FIFO holds data, the status bit is forced to one. Software can flip the status bit by writing a one to it, which matters once the FIFO is empty. The interrupt output is a registered AND of the master enable, the status bit and the source enable.

Bus reads are combinational from `bus_addr` while `bus_rd` is high. A read of the FIFO location pops on the clock edge that ends that cycle.

Top module: `adc_regbank`

## Requirements
- R1: After reset, every location reads zero, `irq` is 0, `settle_mult` is 0 and `res_ready` is 1.
- R2: The master interrupt enable at offset 0x01C is one read/write bit in data bit 31. Data bits 30..0 read as zero.
- R3: The source enable at offset 0x028 is one read/write bit in data bit 0. All other bits read as zero.
- R4: The status bit sits at offset 0x020, data bit 0. It becomes 1 on the edge after any cycle in which the FIFO is non-empty, and stays 1 for as long as data remains. When the FIFO is empty, a write with data bit 0 = 1 flips it and a write with bit 0 = 0 leaves it unchanged. After the FIFO drains, the bit keeps its value until such a write.
- R5: `irq` equals the AND of the master enable, the status bit and the source enable, one clock later.
- R6: The control register at offset 0x100 holds FSTM_W read/write bits in data bits FSTM_W-1..0. Its upper bits read zero. Those stored bits drive `settle_mult`.
- R7: A read at offset 0x104 returns the oldest entry in data bits 15..0 and removes it. Entries come out in push order. A read while the FIFO is empty returns zero and changes no state.
- R8: A result is stored when `res_valid` and `res_ready` are both high. `res_ready` is low exactly when 16 entries are held. The occupancy register at offset 0x108 reads the count, 0 to 16, in its low bits.
- R9: Writes to offsets 0x104 and 0x108 have no effect. Any offset not listed reads zero and accepts no write. Address bits 1..0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 9 | Byte offset within the 0x200 window |
| bus_wr | input | 1 | Write strobe, one beat |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe, one beat |
| bus_rdata | output | 32 | Read data, valid in the same cycle as `bus_rd` |
| res_valid | input | 1 | Conversion result offered |
| res_data | input | 16 | Conversion result |
| res_ready | output | 1 | FIFO has space |
| settle_mult | output | FSTM_W | Settle-time multiplier for the converter core |
| irq | output | 1 | Interrupt, active high |

## Verification
The assertions assume the following about the bus and the producer:
- `bus_addr` is stable and meaningful whenever either strobe is high.
- `bus_wr` and `bus_rd` are not raised together, so a cycle is either a pop, a write or idle.
- The result producer may hold `res_valid` high against a low `res_ready`.

The stimulus keeps within these rules. It drives every input half a period away from the sampling edge, and it picks at most one strobe per cycle. Its random addresses come from the six mapped offsets plus one unmapped offset, with random low address bits.

// File: rtl/adc_regbank_pkg.sv
package adc_regbank_pkg;
  localparam int ADDR_W = 9;
  localparam logic [ADDR_W-1:0] OFS_GIE  = 9'h01C;
  localparam logic [ADDR_W-1:0] OFS_ISR  = 9'h020;
  localparam logic [ADDR_W-1:0] OFS_IER  = 9'h028;
  localparam logic [ADDR_W-1:0] OFS_CTRL = 9'h100;
  localparam logic [ADDR_W-1:0] OFS_FIFO = 9'h104;
  localparam logic [ADDR_W-1:0] OFS_OCC  = 9'h108;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_GIE, SEL_ISR, SEL_IER, SEL_CTRL, SEL_FIFO, SEL_OCC
  } reg_sel_e;

  function automatic reg_sel_e decode_word(input logic [ADDR_W-3:0] word);
    logic [ADDR_W-1:0] a;
    a = {word, 2'b00};
    case (a)
      OFS_GIE:  return SEL_GIE;
      OFS_ISR:  return SEL_ISR;
      OFS_IER:  return SEL_IER;
      OFS_CTRL: return SEL_CTRL;
      OFS_FIFO: return SEL_FIFO;
      OFS_OCC:  return SEL_OCC;
      default:  return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/adc_res_fifo.sv
module adc_res_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [W-1:0]  in_data,
  output logic          in_ready,
  input  logic          pop,
  output logic [W-1:0]  out_data,
  output logic [CW-1:0] count
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  assign in_ready = (count != FULL_CNT);
  assign do_push  = in_valid && in_ready;
  assign do_pop   = pop && (count != '0);
  assign out_data = (count != '0) ? mem[rd_ptr] : '0;

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/adc_irq_ctrl.sv
module adc_irq_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic gie_wr,
  input  logic gie_wd,
  input  logic ien_wr,
  input  logic ien_wd,
  input  logic isr_toggle,
  input  logic src_level,
  output logic gie,
  output logic isr,
  output logic ien,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie <= 1'b0;
      ien <= 1'b0;
      isr <= 1'b0;
      irq <= 1'b0;
    end else begin
      if (gie_wr) gie <= gie_wd;
      if (ien_wr) ien <= ien_wd;
      if (src_level)       isr <= 1'b1;
      else if (isr_toggle) isr <= ~isr;
      irq <= gie & isr & ien;
    end
  end
endmodule

// File: rtl/adc_regbank.sv
module adc_regbank
  import adc_regbank_pkg::*;
#(
  parameter int RES_W   = 16,
  parameter int DEPTH   = 16,
  parameter int FSTM_W  = 4,
  localparam int DATA_W = 32,
  localparam int CW     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              res_valid,
  input  logic [RES_W-1:0]  res_data,
  output logic              res_ready,
  output logic [FSTM_W-1:0] settle_mult,
  output logic              irq
);
  reg_sel_e          sel;
  logic [CW-1:0]     occ;
  logic [RES_W-1:0]  head;
  logic              gie, isr, ien;
  logic [FSTM_W-1:0] ctrl_q;
  logic              unused_bits;

  assign sel         = decode_word(bus_addr[ADDR_W-1:2]);
  assign unused_bits = ^{bus_addr[1:0], bus_wdata[DATA_W-2:FSTM_W]};

  adc_res_fifo #(.W(RES_W), .DEPTH(DEPTH)) fifo_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (res_valid),
    .in_data  (res_data),
    .in_ready (res_ready),
    .pop      (bus_rd && (sel == SEL_FIFO)),
    .out_data (head),
    .count    (occ)
  );

  adc_irq_ctrl irq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .gie_wr     (bus_wr && (sel == SEL_GIE)),
    .gie_wd     (bus_wdata[DATA_W-1]),
    .ien_wr     (bus_wr && (sel == SEL_IER)),
    .ien_wd     (bus_wdata[0]),
    .isr_toggle (bus_wr && (sel == SEL_ISR) && bus_wdata[0]),
    .src_level  (occ != '0),
    .gie        (gie),
    .isr        (isr),
    .ien        (ien),
    .irq        (irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          ctrl_q <= '0;
    else if (bus_wr && sel == SEL_CTRL) ctrl_q <= bus_wdata[FSTM_W-1:0];
  end
  assign settle_mult = ctrl_q;

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (sel)
        SEL_GIE:  bus_rdata = {gie, {(DATA_W-1){1'b0}}};
        SEL_ISR:  bus_rdata = {{(DATA_W-1){1'b0}}, isr};
        SEL_IER:  bus_rdata = {{(DATA_W-1){1'b0}}, ien};
        SEL_CTRL: bus_rdata = {{(DATA_W-FSTM_W){1'b0}}, ctrl_q};
        SEL_FIFO: bus_rdata = {{(DATA_W-RES_W){1'b0}}, head};
        SEL_OCC:  bus_rdata = {{(DATA_W-CW){1'b0}}, occ};
        default:  bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/adc_regbank_chk.sv
module adc_regbank_chk
  import adc_regbank_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [31:0]       bus_rdata,
  input logic              res_valid,
  input logic              res_ready,
  input logic              irq,
  input logic [CW-1:0]     occ,
  input logic              gie,
  input logic              isr,
  input logic              ien
);
  logic [ADDR_W-1:0] al;
  assign al = {bus_addr[ADDR_W-1:2], 2'b00};

  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (gie && isr && ien) |=> irq); // R5
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    !(gie && isr && ien) |=> !irq); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CW'(DEPTH)); // R8
  AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == CW'(DEPTH)) |-> !res_ready); // R8
  AST_STATUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (occ != '0) |=> isr); // R4
  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && al == OFS_FIFO && occ == '0) |-> (bus_rdata == '0)); // R7
  AST_GIE_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && al == OFS_GIE) |-> (bus_rdata[30:0] == '0)); // R2
  AST_WRITE_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_rd && !res_valid) |=> $stable(occ)); // R9
endmodule

bind adc_regbank adc_regbank_chk #(.DEPTH(DEPTH)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_rdata (bus_rdata),
  .res_valid (res_valid),
  .res_ready (res_ready),
  .irq       (irq),
  .occ       (occ),
  .gie       (gie),
  .isr       (isr),
  .ien       (ien)
);

// File: tb/adc_regbank_tb_top.sv
module adc_regbank_tb_top;
  localparam int FW = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [8:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic        res_valid = 1'b0;
  logic [15:0] res_data = '0;
  logic        res_ready;
  logic [FW-1:0] settle_mult;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [15:0]   q[$];
  logic          m_gie = 0, m_isr = 0, m_ien = 0, m_irq = 0;
  logic [FW-1:0] m_ctrl = '0;

  always #10 clk = ~clk;

  adc_regbank #(.FSTM_W(FW)) dut_i (
    .clk, .rst_n, .bus_addr, .bus_wr, .bus_wdata, .bus_rd, .bus_rdata,
    .res_valid, .res_data, .res_ready, .settle_mult, .irq
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [8:0] al(input logic [8:0] a);
    return {a[8:2], 2'b00};
  endfunction

  function automatic logic [31:0] exp_read(input logic [8:0] a);
    case (al(a))
      9'h01C: return {m_gie, 31'b0};
      9'h020: return {31'b0, m_isr};
      9'h028: return {31'b0, m_ien};
      9'h100: return {{(32-FW){1'b0}}, m_ctrl};
      9'h104: return (q.size() != 0) ? {16'b0, q[0]} : 32'b0;
      9'h108: return 32'(q.size());
      default: return 32'b0;
    endcase
  endfunction

  function automatic string tag_of(input logic [8:0] a);
    case (al(a))
      9'h01C: return "R2 gie read";
      9'h020: return "R4 status read";
      9'h028: return "R3 enable read";
      9'h100: return "R6 control read";
      9'h104: return "R7 fifo read";
      9'h108: return "R8 occupancy read";
      default: return "R9 unmapped read";
    endcase
  endfunction

  task automatic cyc(input logic [8:0] a, input bit w, input logic [31:0] wd,
                     input bit r, input bit pv, input logic [15:0] pd,
                     output logic [31:0] got);
    int n;
    logic nirq;
    bus_addr = a; bus_wr = w; bus_wdata = wd; bus_rd = r;
    res_valid = pv; res_data = pd;
    #1;
    got = bus_rdata;
    if (r) chk(bus_rdata == exp_read(a), tag_of(a), bus_rdata, exp_read(a));
    chk(res_ready == (q.size() < 16), "R8 ready", 32'(res_ready), 32'(q.size() < 16));
    chk(irq == m_irq, "R5 irq", 32'(irq), 32'(m_irq));
    chk(settle_mult == m_ctrl, "R6 settle_mult", 32'(settle_mult), 32'(m_ctrl));
    @(posedge clk);
    n = q.size();
    nirq = m_gie & m_isr & m_ien;
    if (n > 0) m_isr = 1'b1;
    else if (w && al(a) == 9'h020 && wd[0]) m_isr = ~m_isr;
    if (w && al(a) == 9'h01C) m_gie = wd[31];
    if (w && al(a) == 9'h028) m_ien = wd[0];
    if (w && al(a) == 9'h100) m_ctrl = wd[FW-1:0];
    if (r && al(a) == 9'h104 && n > 0) void'(q.pop_front());
    if (pv && n < 16) q.push_back(pd);
    m_irq = nirq;
    @(negedge clk);
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] got);
    cyc(a, 0, 0, 1, 0, 0, got);
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    logic [31:0] g;
    cyc(a, 1, d, 0, 0, 0, g);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog all-reqs act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] g;
    logic [8:0] amap [7];
    int seed_dummy;
    amap[0] = 9'h01C; amap[1] = 9'h020; amap[2] = 9'h028; amap[3] = 9'h100;
    amap[4] = 9'h104; amap[5] = 9'h108; amap[6] = 9'h1F0;
    seed_dummy = $urandom(32'h5EED);

    repeat (3) @(negedge clk);
    chk(irq == 1'b0, "R1 irq in reset", 32'(irq), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: every location reads zero after reset
    for (int i = 0; i < 7; i++) begin
      rd(amap[i], g);
      chk(g == 0, "R1 reset value", g, 0);
    end
    chk(res_ready == 1'b1, "R1 ready after reset", 32'(res_ready), 1);

    // R2, R3, R6: field positions
    wr(9'h01C, 32'hFFFF_FFFF); rd(9'h01C, g);
    chk(g == 32'h8000_0000, "R2 gie bit31 only", g, 32'h8000_0000);
    wr(9'h028, 32'hFFFF_FFFF); rd(9'h028, g);
    chk(g == 32'h1, "R3 enable bit0 only", g, 1);
    wr(9'h100, 32'hFFFF_FFFF); rd(9'h100, g);
    chk(g == 32'hF, "R6 control low bits", g, 32'hF);

    // R4/R5: toggle while empty
    wr(9'h020, 32'h1); rd(9'h020, g);
    chk(g == 1, "R4 toggle sets", g, 1);
    rd(9'h108, g);
    chk(irq == 1'b1, "R5 irq raised", 32'(irq), 1);
    wr(9'h020, 32'hFFFF_FFFE); rd(9'h020, g);
    chk(g == 1, "R4 zero write keeps", g, 1);
    wr(9'h020, 32'h1); rd(9'h020, g);
    chk(g == 0, "R4 toggle clears", g, 0);

    // R8: fill past full
    for (int i = 0; i < 17; i++) cyc(9'h1F0, 0, 0, 0, 1, 16'hA000 + 16'(i), g);
    rd(9'h108, g);
    chk(g == 16, "R8 occupancy full", g, 16);
    chk(res_ready == 1'b0, "R8 ready low when full", 32'(res_ready), 0);

    // R9: writes to read-only locations
    wr(9'h104, 32'hFFFF_FFFF); wr(9'h108, 32'h0); wr(9'h1F0, 32'hFFFF_FFFF);
    rd(9'h108, g);
    chk(g == 16, "R9 ro writes ignored", g, 16);

    // R4: toggle while non-empty stays set
    wr(9'h020, 32'h1); rd(9'h020, g);
    chk(g == 1, "R4 held while data", g, 1);

    // R7: order, then empty read
    for (int i = 0; i < 16; i++) begin
      rd(9'h105, g);
      chk(g == 32'hA000 + 32'(i), "R7 pop order", g, 32'hA000 + 32'(i));
    end
    rd(9'h104, g);
    chk(g == 0, "R7 empty read zero", g, 0);
    rd(9'h108, g);
    chk(g == 0, "R7 empty read no change", g, 0);
    rd(9'h020, g);
    chk(g == 1, "R4 stays after drain", g, 1);

    // random mix
    for (int k = 0; k < 3000; k++) begin
      int op;
      logic [8:0] a;
      a = amap[$urandom_range(0, 6)] | 9'($urandom_range(0, 3));
      op = $urandom_range(0, 9);
      cyc(a, op < 3, $urandom, op >= 3 && op < 8,
          $urandom_range(0, 9) < 4, 16'($urandom), g);
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule